// File: doc/BRIEF.md
# Byte-Lane Sequencing Bridge to a Narrow Peripheral Bus

This block sits between a 32-bit memory-mapped slave port and an external 8-bit peripheral bus that several devices share. The slave port carries a byte address, separate read and write requests, four byte enables and a waitrequest back to the master. The external side drives a device address, one active-low chip select per device, and shared active-low read and write strobes. Its 8-bit data path is split into a driven output, a sampled input and an output-enable for the pad.

Each request is turned into a series of single-byte external cycles, one for every enabled byte lane, issued from the lowest enabled lane upwards. The master is held in waitrequest until the last of them has finished. A read therefore never touches a byte that software did not ask for, so peripheral registers that clear on read next to the target are left alone. Each byte cycle has a fixed number of setup, strobe and hold clocks set by parameters.

Top module: `byte_lane_bridge`

## Requirements
- R1: After reset, and with no request pending, all chip selects, both strobes are high, the data output-enable is low and waitrequest is low.
- R2: A request makes exactly one external byte cycle for every byte-enable bit that is set and none for cleared bits, for reads and writes alike (4 bits set gives 4 cycles, 2 gives 2, 1 gives 1).
- R3: The byte cycles of one request run in ascending lane order, starting with the lowest enabled lane.
- R4: Address bits [19:17] pick chip select number n (line x_cs_n[n] goes low, and no other line does). The device address is bits [16:2] of the request address with the lane number (0..3) in its two low bits.
- R5: Each byte cycle holds its chip select low for SETUP_CYC clocks with both strobes high, then STROBE_CYC clocks with one strobe low, then HOLD_CYC clocks with both strobes high. Address and chip select do not change while a strobe is low.
- R6: In a write cycle, x_dout carries byte lane k of the write data (bits 8k+7..8k) and x_dout_en is high. x_dout_en is never high while the read strobe is low.
- R7: Read data is sampled on the last strobe clock into byte lane k of s_rdata. Lanes that are not enabled read as zero. s_rdata is valid in the cycle in which waitrequest is low.
- R8: For a request with n enabled lanes, waitrequest is high for exactly 1 + n*(SETUP_CYC+STROBE_CYC+HOLD_CYC) clocks and then low for one clock.
- R9: A request with all byte enables clear completes in its first cycle with waitrequest low. It makes no external cycle, and its read data is zero.
- R10: Reads pulse only x_rd_n and writes pulse only x_wr_n; the two strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_addr | input | 20 | Word-aligned byte address of the request |
| s_read | input | 1 | Read request |
| s_write | input | 1 | Write request |
| s_byteen | input | 4 | Byte lane enables |
| s_wdata | input | 32 | Write data |
| s_rdata | output | 32 | Read data, valid while waitrequest is low |
| s_waitreq | output | 1 | Stall to the master |
| x_addr | output | 17 | External device byte address |
| x_cs_n | output | 8 | Active-low chip selects |
| x_rd_n | output | 1 | Shared active-low read strobe |
| x_wr_n | output | 1 | Shared active-low write strobe |
| x_dout | output | 8 | External data out |
| x_dout_en | output | 1 | Drive enable for external data |
| x_din | input | 8 | External data in |

## Verification
Writes and reads are issued with all four lanes, with the upper half-word, with a single middle byte, and with the sparse pattern 1001. The full and half-word cases show the lane count, and the single byte shows that a read stays on one address. The sparse pattern shows ascending order and the zero filling of skipped lanes. A request with no lanes enabled separates the immediate-completion path from a sequenced one, and a sweep of the top address bits checks that each chip select is reached on its own.

// File: rtl/blb_pkg.sv
package blb_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SETUP,
      PH_STROBE,
      PH_HOLD,
      PH_DONE
   } blb_phase_e;

endpackage

// File: rtl/blb_lane_pick.sv
module blb_lane_pick #(
   parameter int LANES = 4,
   parameter int SEL_W = 2
) (
   input  logic [LANES-1:0] mask,
   output logic             any,
   output logic [SEL_W-1:0] idx
);

   // Lowest set bit wins: scan downward so the last hit is the lowest.
   always_comb begin
      idx = '0;
      for (int i = LANES - 1; i >= 0; i--) begin
         if (mask[i]) idx = SEL_W'(i);
      end
   end

   assign any = |mask;

endmodule

// File: rtl/blb_phase_timer.sv
module blb_phase_timer #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             last
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign last = (cnt_q == '0);

endmodule

// File: rtl/blb_cs_decode.sv
module blb_cs_decode #(
   parameter int CS_BITS = 3,
   parameter int NUM_CS  = 8
) (
   input  logic               en,
   input  logic [CS_BITS-1:0] sel,
   output logic [NUM_CS-1:0]  cs_n
);

   for (genvar g = 0; g < NUM_CS; g++) begin : g_line
      assign cs_n[g] = !(en && (sel == CS_BITS'(g)));
   end

endmodule

// File: rtl/blb_read_pack.sv
module blb_read_pack #(
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   parameter int SEL_W  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clear,
   input  logic                    capture,
   input  logic [SEL_W-1:0]        idx,
   input  logic [LANE_W-1:0]       din,
   output logic [LANES*LANE_W-1:0] data
);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] byte_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            byte_q <= '0;
         end else if (clear) begin
            byte_q <= '0;
         end else if (capture && (idx == SEL_W'(g))) begin
            byte_q <= din;
         end
      end

      assign data[g*LANE_W +: LANE_W] = byte_q;
   end

endmodule

// File: rtl/byte_lane_bridge.sv
module byte_lane_bridge #(
   parameter int ADDR_W     = 20,
   parameter int DATA_W     = 32,
   parameter int LANE_W     = 8,
   parameter int CS_BITS    = 3,
   parameter int SETUP_CYC  = 2,
   parameter int STROBE_CYC = 3,
   parameter int HOLD_CYC   = 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [ADDR_W-1:0]            s_addr,
   input  logic                         s_read,
   input  logic                         s_write,
   input  logic [DATA_W/LANE_W-1:0]     s_byteen,
   input  logic [DATA_W-1:0]            s_wdata,
   output logic [DATA_W-1:0]            s_rdata,
   output logic                         s_waitreq,
   output logic [ADDR_W-CS_BITS-1:0]    x_addr,
   output logic [(1<<CS_BITS)-1:0]      x_cs_n,
   output logic                         x_rd_n,
   output logic                         x_wr_n,
   output logic [LANE_W-1:0]            x_dout,
   output logic                         x_dout_en,
   input  logic [LANE_W-1:0]            x_din
);

   import blb_pkg::*;

   localparam int LANES  = DATA_W / LANE_W;
   localparam int SEL_W  = (LANES > 1) ? $clog2(LANES) : 1;
   localparam int DEV_W  = ADDR_W - CS_BITS;
   localparam int NUM_CS = 1 << CS_BITS;
   localparam int T_MAX  = (SETUP_CYC > STROBE_CYC)
                           ? ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC)
                           : ((STROBE_CYC > HOLD_CYC) ? STROBE_CYC : HOLD_CYC);
   localparam int CNT_W  = (T_MAX > 1) ? $clog2(T_MAX) : 1;
   localparam logic [CNT_W-1:0] SETUP_LD  = CNT_W'(SETUP_CYC - 1);
   localparam logic [CNT_W-1:0] STROBE_LD = CNT_W'(STROBE_CYC - 1);
   localparam logic [CNT_W-1:0] HOLD_LD   = CNT_W'(HOLD_CYC - 1);

   // ---------------- elaboration checks ----------------
   if (DATA_W % LANE_W != 0) begin : g_bad_lane_div
      $error("DATA_W must be a multiple of LANE_W");
   end
   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("lane count must be a power of two of at least 2");
   end
   if (DEV_W <= SEL_W) begin : g_bad_addr
      $error("address too narrow for chip-select and lane bits");
   end
   if (SETUP_CYC < 1 || STROBE_CYC < 1 || HOLD_CYC < 1) begin : g_bad_timing
      $error("setup, strobe and hold must each be at least one clock");
   end

   // ---------------- request state ----------------
   blb_phase_e         phase_q;
   logic [LANES-1:0]   pend_q;
   logic [ADDR_W-1:0]  addr_q;
   logic               wr_q;
   logic [DATA_W-1:0]  wdata_q;

   logic               req;
   logic               accept;
   logic               zero_be;
   logic               pend_any;
   logic [SEL_W-1:0]   cur_idx;
   logic [LANES-1:0]   cur_oh;
   logic               rest_any;
   logic               tm_last;
   logic               tm_load;
   logic [CNT_W-1:0]   tm_val;
   logic               in_cyc;
   logic               rd_capture;
   logic [DATA_W-1:0]  pack_data;

   assign req     = s_read | s_write;
   assign zero_be = (s_byteen == '0);
   assign accept  = (phase_q == PH_IDLE) && req && !zero_be;

   blb_lane_pick #(
      .LANES (LANES),
      .SEL_W (SEL_W)
   ) u_pick (
      .mask (pend_q),
      .any  (pend_any),
      .idx  (cur_idx)
   );

   assign cur_oh   = LANES'(1) << cur_idx;
   assign rest_any = |(pend_q & ~cur_oh);

   // timer reload at each phase entry
   always_comb begin
      tm_load = 1'b0;
      tm_val  = SETUP_LD;
      unique case (phase_q)
         PH_IDLE: begin
            tm_load = accept;
            tm_val  = SETUP_LD;
         end
         PH_SETUP: begin
            tm_load = tm_last;
            tm_val  = STROBE_LD;
         end
         PH_STROBE: begin
            tm_load = tm_last;
            tm_val  = HOLD_LD;
         end
         PH_HOLD: begin
            tm_load = tm_last && rest_any;
            tm_val  = SETUP_LD;
         end
         default: begin
            tm_load = 1'b0;
            tm_val  = SETUP_LD;
         end
      endcase
   end

   blb_phase_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tm_load),
      .load_val (tm_val),
      .last     (tm_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         pend_q  <= '0;
         addr_q  <= '0;
         wr_q    <= 1'b0;
         wdata_q <= '0;
      end else begin
         unique case (phase_q)
            PH_IDLE: begin
               if (accept) begin
                  phase_q <= PH_SETUP;
                  pend_q  <= s_byteen;
                  addr_q  <= s_addr;
                  wr_q    <= s_write;
                  wdata_q <= s_wdata;
               end
            end
            PH_SETUP: begin
               if (tm_last) phase_q <= PH_STROBE;
            end
            PH_STROBE: begin
               if (tm_last) phase_q <= PH_HOLD;
            end
            PH_HOLD: begin
               if (tm_last) begin
                  pend_q  <= pend_q & ~cur_oh;
                  phase_q <= rest_any ? PH_SETUP : PH_DONE;
               end
            end
            PH_DONE: begin
               phase_q <= PH_IDLE;
            end
            default: begin
               phase_q <= PH_IDLE;
            end
         endcase
      end
   end

   // ---------------- read assembly ----------------
   assign rd_capture = (phase_q == PH_STROBE) && tm_last && !wr_q;

   blb_read_pack #(
      .LANES  (LANES),
      .LANE_W (LANE_W),
      .SEL_W  (SEL_W)
   ) u_pack (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (accept),
      .capture (rd_capture),
      .idx     (cur_idx),
      .din     (x_din),
      .data    (pack_data)
   );

   // ---------------- external side ----------------
   assign in_cyc = (phase_q == PH_SETUP) || (phase_q == PH_STROBE) || (phase_q == PH_HOLD);

   blb_cs_decode #(
      .CS_BITS (CS_BITS),
      .NUM_CS  (NUM_CS)
   ) u_cs (
      .en   (in_cyc),
      .sel  (addr_q[ADDR_W-1:DEV_W]),
      .cs_n (x_cs_n)
   );

   assign x_addr    = {addr_q[DEV_W-1:SEL_W], cur_idx};
   assign x_rd_n    = !((phase_q == PH_STROBE) && !wr_q);
   assign x_wr_n    = !((phase_q == PH_STROBE) && wr_q);
   assign x_dout    = wdata_q[cur_idx*LANE_W +: LANE_W];
   assign x_dout_en = in_cyc && wr_q;

   // ---------------- master side ----------------
   assign s_waitreq = req && (phase_q != PH_DONE) && !((phase_q == PH_IDLE) && zero_be);
   assign s_rdata   = (phase_q == PH_DONE) ? pack_data : '0;

   // ---------------- assertions ----------------
   // R4
   cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~x_cs_n));

   // R10
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!x_rd_n && !x_wr_n));

   // R5
   strobe_has_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!x_rd_n || !x_wr_n) |-> (x_cs_n != '1));

   // R5
   addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((!x_rd_n || !x_wr_n) && $past(!x_rd_n || !x_wr_n)) |-> ($stable(x_addr) && $stable(x_cs_n)));

   // R6
   no_drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(x_dout_en && !x_rd_n));

   // R9
   zero_be_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_read && (s_byteen == '0) && !s_waitreq && (x_cs_n == '1)) |-> (s_rdata == '0));

   // R2
   pend_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_cyc |-> pend_any);

endmodule

// File: tb/byte_lane_bridge_bench.sv
module byte_lane_bridge_bench;

   localparam int S_CYC = 2;
   localparam int T_CYC = 3;
   localparam int H_CYC = 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] s_addr = '0;
   logic        s_read = 1'b0;
   logic        s_write = 1'b0;
   logic [3:0]  s_byteen = '0;
   logic [31:0] s_wdata = '0;
   logic [31:0] s_rdata;
   logic        s_waitreq;
   logic [16:0] x_addr;
   logic [7:0]  x_cs_n;
   logic        x_rd_n;
   logic        x_wr_n;
   logic [7:0]  x_dout;
   logic        x_dout_en;
   logic [7:0]  x_din;

   int n_checks = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   byte_lane_bridge u_byte_lane_bridge (
      .clk       (clk),
      .rst_n     (rst_n),
      .s_addr    (s_addr),
      .s_read    (s_read),
      .s_write   (s_write),
      .s_byteen  (s_byteen),
      .s_wdata   (s_wdata),
      .s_rdata   (s_rdata),
      .s_waitreq (s_waitreq),
      .x_addr    (x_addr),
      .x_cs_n    (x_cs_n),
      .x_rd_n    (x_rd_n),
      .x_wr_n    (x_wr_n),
      .x_dout    (x_dout),
      .x_dout_en (x_dout_en),
      .x_din     (x_din)
   );

   // ---------------- peripheral model ----------------
   function automatic logic [7:0] dev_byte(input logic [16:0] a, input logic [2:0] c);
      return a[7:0] ^ 8'h3C ^ {c, 5'b00000};
   endfunction

   logic [2:0] cs_now;
   always_comb begin
      cs_now = '0;
      for (int i = 0; i < 8; i++) if (!x_cs_n[i]) cs_now = 3'(i);
   end
   assign x_din = dev_byte(x_addr, cs_now);

   // ---------------- bus monitor ----------------
   logic [16:0] ev_addr [16];
   logic [2:0]  ev_cs   [16];
   logic        ev_wr   [16];
   logic [7:0]  ev_data [16];
   int          n_ev = 0;
   int          wcnt = 0;
   int          bad_width = 0;
   int          bad_oe = 0;
   int          bad_cs = 0;
   logic        prev_strb = 1'b0;

   always @(negedge clk) begin
      logic strb;
      strb = !x_rd_n || !x_wr_n;
      if (rst_n) begin
         if (strb && !prev_strb && n_ev < 16) begin
            ev_addr[n_ev] = x_addr;
            ev_cs[n_ev]   = cs_now;
            ev_wr[n_ev]   = !x_wr_n;
            ev_data[n_ev] = x_dout;
            n_ev = n_ev + 1;
         end
         if (strb) wcnt = wcnt + 1;
         else if (prev_strb) begin
            if (wcnt != T_CYC) bad_width = bad_width + 1;
            wcnt = 0;
         end
         if (!x_wr_n && !x_dout_en) bad_oe = bad_oe + 1;
         if (!x_rd_n && x_dout_en) bad_oe = bad_oe + 1;
         if (strb && $countones(~x_cs_n) != 1) bad_cs = bad_cs + 1;
      end
      prev_strb = strb;
   end

   // ---------------- helpers ----------------
   task automatic check(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks = n_checks + 1;
      if (!ok) begin
         n_err = n_err + 1;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   task automatic run_access(input logic wr, input logic [19:0] addr, input logic [3:0] be,
                             input logic [31:0] wd, output logic [31:0] rd, output int waits);
      @(negedge clk);
      n_ev = 0;
      s_addr = addr; s_byteen = be; s_wdata = wd;
      s_read = !wr; s_write = wr;
      #1;
      waits = 0;
      while (s_waitreq && waits < 1000) begin
         waits = waits + 1;
         @(negedge clk);
         #1;
      end
      rd = s_rdata;
      s_read = 1'b0; s_write = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic check_access(input logic wr, input logic [19:0] addr, input logic [3:0] be, input logic [31:0] wd);
      logic [31:0] rd;
      logic [31:0] exp_rd;
      logic [16:0] ea;
      int waits;
      int n_exp;
      int j;
      run_access(wr, addr, be, wd, rd, waits);
      n_exp = $countones(be);
      exp_rd = '0;
      j = 0;
      // R2 one cycle per enabled lane
      check(n_ev == n_exp, "R2 external cycle count", 32'(n_ev), 32'(n_exp));
      for (int k = 0; k < 4; k++) begin
         if (be[k]) begin
            ea = {addr[16:2], 2'(k)};
            exp_rd[k*8 +: 8] = dev_byte(ea, addr[19:17]);
            if (j < n_ev) begin
               // R3 ascending order, R4 address mapping
               check(ev_addr[j] == ea, "R3/R4 byte cycle address", 32'(ev_addr[j]), 32'(ea));
               check(ev_cs[j] == addr[19:17], "R4 chip select index", 32'(ev_cs[j]), 32'(addr[19:17]));
               // R10 strobe kind
               check(ev_wr[j] == wr, "R10 strobe kind", 32'(ev_wr[j]), 32'(wr));
               if (wr) check(ev_data[j] == wd[k*8 +: 8], "R6 write byte", 32'(ev_data[j]), 32'(wd[k*8 +: 8]));
            end
            j = j + 1;
         end
      end
      // R8 wait length
      check(waits == ((be == 4'b0) ? 0 : 1 + n_exp * (S_CYC + T_CYC + H_CYC)),
            "R8 waitrequest length", 32'(waits), 32'((be == 4'b0) ? 0 : 1 + n_exp * (S_CYC + T_CYC + H_CYC)));
      // R7 read assembly, zero lanes
      if (!wr) check(rd == exp_rd, "R7 read data", rd, exp_rd);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      check(x_cs_n == 8'hFF, "R1 chip selects in reset", 32'(x_cs_n), 32'hFF);
      check(x_rd_n && x_wr_n, "R1 strobes in reset", {30'b0, x_rd_n, x_wr_n}, 32'h3);
      @(negedge clk); rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(x_cs_n == 8'hFF, "R1 chip selects idle", 32'(x_cs_n), 32'hFF);
      check(!x_dout_en, "R1 output enable idle", 32'(x_dout_en), 32'h0);
      check(!s_waitreq, "R1 waitrequest idle", 32'(s_waitreq), 32'h0);
   endtask

   task automatic t_writes();
      check_access(1'b1, 20'h2_0010, 4'b1111, 32'hA1B2C3D4);
      check_access(1'b1, 20'h4_1234, 4'b1100, 32'h55667788);
      check_access(1'b1, 20'h0_00F8, 4'b0100, 32'h00EE0000);
   endtask

   task automatic t_reads();
      check_access(1'b0, 20'h6_0100, 4'b1111, 32'h0);
      check_access(1'b0, 20'h8_0A40, 4'b0011, 32'h0);
      check_access(1'b0, 20'hE_0004, 4'b0010, 32'h0);
   endtask

   task automatic t_sparse();
      // R3 order and R7 zeros with a gap pattern
      check_access(1'b0, 20'hA_0F0C, 4'b1001, 32'h0);
      check_access(1'b1, 20'hC_0200, 4'b1010, 32'h12345678);
   endtask

   task automatic t_zero();
      logic [31:0] rd;
      int waits;
      // R9 empty byte enables
      run_access(1'b0, 20'h2_0000, 4'b0000, 32'h0, rd, waits);
      check(waits == 0, "R9 read completes at once", 32'(waits), 32'h0);
      check(n_ev == 0, "R9 read makes no cycle", 32'(n_ev), 32'h0);
      check(rd == 32'h0, "R9 read data zero", rd, 32'h0);
      run_access(1'b1, 20'h2_0000, 4'b0000, 32'hFFFF_FFFF, rd, waits);
      check(waits == 0 && n_ev == 0, "R9 write no cycle", 32'(n_ev), 32'h0);
   endtask

   task automatic t_cs_sweep();
      for (int c = 0; c < 8; c++) begin
         check_access(1'b0, {3'(c), 17'h0_0120}, 4'b0001, 32'h0);
      end
   endtask

   task automatic t_final();
      check(bad_width == 0, "R5 strobe width", 32'(bad_width), 32'h0);
      check(bad_oe == 0, "R6 output enable versus strobe", 32'(bad_oe), 32'h0);
      check(bad_cs == 0, "R4 single chip select during strobe", 32'(bad_cs), 32'h0);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks = n_checks + 1;
      n_err = n_err + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_writes();
      t_reads();
      t_sparse();
      t_zero();
      t_cs_sweep();
      t_final();
      finish_run();
   end

endmodule